// File: doc/BRIEF.md
# Dual-Line Serial Flash Read Controller

This block is the host side of a serial flash read path. A request carries a 24-bit start address and a byte count. The controller lowers chip select, then sends an 8-bit read command and the address one bit per clock on a single output line. Eight idle clocks follow. After that the flash returns data on two lines at once, so each byte takes four serial clocks. The controller packs the bit pairs into bytes and hands them downstream on a valid/ready stream.

The serial clock idles low. The flash changes its data after a falling edge. The controller samples both return lines at the moment it raises the clock. The controller's own output line changes only while the clock is low. A programmable half-period sets the clock rate and is captured when a request is accepted. The downstream consumer may refuse bytes. When a finished byte is still waiting, the controller holds the serial clock low at the next byte boundary, so no data is dropped. When the count is used up, the controller raises chip select and pulses `done`. A count of zero completes at once and the flash bus does not move.

Top module: `dual_read_master`

## Requirements
- R1: After reset, `fl_cs_n` is 1, `fl_sck` is 0, `out_valid` is 0, `done` is 0 and `req_ready` is 1.
- R2: Serial clocks 0 to 7 of a transaction carry the parameter `READ_CMD` (default 8'h3B) on `fl_mosi`, most significant bit first. `fl_mosi` holds steady for as long as `fl_sck` is high.
- R3: Serial clocks 8 to 31 carry all 24 bits of `req_addr`, most significant bit first. This includes bits 23 and 22, which the flash ignores.
- R4: Serial clocks 32 to 39 are dummy clocks. `fl_mosi` is 0 during them, and nothing sampled during them reaches the output.
- R5: From clock 40 onward, every rising edge captures one bit pair. `fl_rx_odd` supplies bits 7, 5, 3, 1 and `fl_rx_even` supplies bits 6, 4, 2, 0, highest pair first. Four clocks make one byte.
- R6: `fl_sck` stays low whenever `fl_cs_n` is high. Every high phase lasts `cfg_half`+1 system cycles. Every low phase lasts `cfg_half`+1 system cycles, except for the hold at a data-byte boundary. The value of `cfg_half` used is the one captured at acceptance.
- R7: A request with a count N > 0 runs exactly 40+4N serial clocks and delivers N bytes in address order. `fl_cs_n` rises in the same cycle as the final falling clock edge, and `done` is high for that one cycle.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` is held. No rising clock edge that would begin a data byte happens while an earlier byte is still waiting.
- R9: A request with a count of 0 raises `done` in the cycle after acceptance, and `fl_cs_n` stays high.
- R10: Between two transactions, `fl_cs_n` stays high for at least `cfg_half`+1 system cycles.
- R11: `req_ready` is 1 only while no transaction is in progress. A request offered during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half | input | DIV_W | Serial clock half-period minus one, in system cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Number of bytes to read |
| done | output | 1 | One-cycle pulse when a request finishes |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Read byte |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_sck | output | 1 | Flash serial clock, idles low |
| fl_mosi | output | 1 | Command and address line to the flash |
| fl_rx_even | input | 1 | Return line carrying the even data bits |
| fl_rx_odd | input | 1 | Return line carrying the odd data bits |

## Verification
The properties are written so that any sequence of `out_ready` values keeps them true. They do assume that reset is not applied in the middle of a held byte, and that a zero-length request is never offered in two consecutive cycles. The bench offers requests only while `req_ready` is high, except for deliberate junk requests during a transfer. The behavioural flash model changes the return lines only right after a falling clock edge. It places deliberate ones on those lines during the dummy clocks, so any sample taken there would corrupt the data. The ready pattern switches between always-ready, a pseudo-random pattern and long refusal windows, so the byte-boundary hold is exercised at several clock rates.

// File: rtl/dqr_pkg.sv
package dqr_pkg;

    localparam int CMD_W        = 8;
    localparam int ADDR_W       = 24;
    localparam int DUMMY_CLKS   = 8;
    localparam int HDR_W        = CMD_W + ADDR_W;
    localparam int DATA_CLK     = HDR_W + DUMMY_CLKS;
    localparam int BYTE_W       = 8;
    localparam int LANES        = 2;
    localparam int CLKS_PER_BYTE = BYTE_W / LANES;
    localparam int CK_W         = $clog2(DATA_CLK + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_GAP  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/dqr_phase.sv
module dqr_phase #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             phase_end
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } ph_regs_t;

    ph_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        phase_end = run && (r_q.cnt == half);
        if (clear) begin
            r_d.cnt = '0;
        end else if (run) begin
            r_d.cnt = phase_end ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dqr_hdr_shift.sv
module dqr_hdr_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         mosi
);
    typedef struct packed {
        logic [W-1:0] sr;
    } hs_regs_t;

    hs_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.sr = load_val;
        end else if (shift) begin
            r_d.sr = {r_q.sr[W-2:0], 1'b0};
        end
        mosi = r_q.sr[W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dqr_byte_asm.sv
module dqr_byte_asm #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              sample,
    input  logic [LANES-1:0]  lanes,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val,
    output logic              step_zero
);
    localparam int STEPS  = BYTE_W / LANES;
    localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [STEP_W-1:0] step;
    } ba_regs_t;

    ba_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        byte_val  = {r_q.acc[BYTE_W-LANES-1:0], lanes};
        byte_done = sample && (r_q.step == STEP_W'(STEPS - 1));
        step_zero = (r_q.step == '0);
        if (clear) begin
            r_d.acc  = '0;
            r_d.step = '0;
        end else if (sample) begin
            r_d.acc  = byte_val;
            r_d.step = byte_done ? '0 : r_q.step + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dqr_out_reg.sv
module dqr_out_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic         v;
        logic [W-1:0] d;
    } or_regs_t;

    or_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (load) begin
            r_d.v = 1'b1;
            r_d.d = din;
        end else if (r_q.v && ready) begin
            r_d.v = 1'b0;
        end
        valid = r_q.v;
        dout  = r_q.d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/dual_read_master.sv
module dual_read_master #(
    parameter logic [7:0] READ_CMD = 8'h3B,
    parameter int         LEN_W    = 16,
    parameter int         DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             done,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data,
    output logic             fl_cs_n,
    output logic             fl_sck,
    output logic             fl_mosi,
    input  logic             fl_rx_even,
    input  logic             fl_rx_odd
);
    import dqr_pkg::*;

    typedef struct packed {
        seq_state_t       state;
        logic             cs_n;
        logic             sck;
        logic [CK_W-1:0]  ck;
        logic [LEN_W-1:0] left;
        logic [DIV_W-1:0] half;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              accept, accept_go, in_data, stall, run;
    logic              phase_end, sample, shift;
    logic              byte_done, step_zero;
    logic [BYTE_W-1:0] byte_val;

    dqr_phase #(.DIV_W(DIV_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept_go),
        .run       (run),
        .half      (r_q.half),
        .phase_end (phase_end)
    );

    dqr_hdr_shift #(.W(HDR_W)) u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_go),
        .load_val ({READ_CMD, req_addr}),
        .shift    (shift),
        .mosi     (fl_mosi)
    );

    dqr_byte_asm #(.BYTE_W(BYTE_W), .LANES(LANES)) u_asm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept_go),
        .sample    (sample),
        .lanes     ({fl_rx_odd, fl_rx_even}),
        .byte_done (byte_done),
        .byte_val  (byte_val),
        .step_zero (step_zero)
    );

    dqr_out_reg #(.W(BYTE_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (byte_done),
        .din   (byte_val),
        .ready (out_ready),
        .valid (out_valid),
        .dout  (out_data)
    );

    always_comb begin
        accept    = (r_q.state == ST_IDLE) && req_valid;
        accept_go = accept && (req_len != '0);
        in_data   = (r_q.ck == CK_W'(DATA_CLK));
        stall     = (r_q.state == ST_LOW) && in_data && step_zero && out_valid;
        run       = ((r_q.state == ST_LOW) && !stall) ||
                    (r_q.state == ST_HIGH) || (r_q.state == ST_GAP);
        sample    = (r_q.state == ST_LOW) && phase_end && in_data;
        shift     = (r_q.state == ST_HIGH) && phase_end;

        r_d      = r_q;
        r_d.done = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (accept_go) begin
                        r_d.state = ST_LOW;
                        r_d.cs_n  = 1'b0;
                        r_d.sck   = 1'b0;
                        r_d.ck    = '0;
                        r_d.left  = req_len;
                        r_d.half  = cfg_half;
                    end else begin
                        r_d.done  = 1'b1;
                    end
                end
            end
            ST_LOW: begin
                if (phase_end) begin
                    r_d.sck   = 1'b1;
                    r_d.state = ST_HIGH;
                    if (byte_done) r_d.left = r_q.left - 1'b1;
                end
            end
            ST_HIGH: begin
                if (phase_end) begin
                    r_d.sck = 1'b0;
                    if (!in_data) r_d.ck = r_q.ck + 1'b1;
                    if (in_data && step_zero && (r_q.left == '0)) begin
                        r_d.state = ST_GAP;
                        r_d.cs_n  = 1'b1;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_LOW;
                    end
                end
            end
            default: begin
                if (phase_end) r_d.state = ST_IDLE;
            end
        endcase

        req_ready = (r_q.state == ST_IDLE);
        done      = r_q.done;
        fl_cs_n   = r_q.cs_n;
        fl_sck    = r_q.sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/dual_read_master_chk.sv
module dual_read_master_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [LEN_W-1:0] req_len,
    input logic             done,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             fl_cs_n,
    input logic             fl_sck,
    input logic             fl_mosi
);
    // R6: clock parked low whenever the flash is deselected
    p_sck_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cs_n |-> !fl_sck);

    // R2: output line never moves during a high clock phase
    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fl_sck |-> $stable(fl_mosi));

    // R8: a refused byte stays on the stream unchanged
    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: completion is reported only with the flash deselected
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (fl_cs_n && !fl_sck));

    // R9: an empty request finishes in the next cycle
    p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_len == '0)) |=> (done && fl_cs_n));

    // R11: requests are taken only while the bus is released
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> fl_cs_n);
endmodule

bind dual_read_master dual_read_master_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_len   (req_len),
    .done      (done),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .fl_cs_n   (fl_cs_n),
    .fl_sck    (fl_sck),
    .fl_mosi   (fl_mosi)
);

// File: tb/dual_read_master_test.sv
module dual_read_master_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] CMD = 8'h3B;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_half = 8'd0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = 24'd0;
    logic [15:0] req_len = 16'd0;
    logic        out_ready = 1'b1;
    logic        fl_rx_even = 1'b0;
    logic        fl_rx_odd = 1'b0;
    logic        req_ready, done, out_valid, fl_cs_n, fl_sck, fl_mosi;
    logic [7:0]  out_data;

    dual_read_master #(.READ_CMD(CMD), .LEN_W(16), .DIV_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_half(cfg_half),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .done(done), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .fl_cs_n(fl_cs_n),
        .fl_sck(fl_sck), .fl_mosi(fl_mosi), .fl_rx_even(fl_rx_even),
        .fl_rx_odd(fl_rx_odd)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit ended = 0;
    bit mon_on = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        logic [21:0] m;
        logic [7:0]  lo;
        m  = a[21:0];
        lo = m[7:0] * 8'd37;
        return lo ^ m[15:8] ^ {2'b00, m[21:16]} ^ 8'h5A;
    endfunction

    // reference state kept by the bench
    logic [7:0]  exp_q[$];
    logic [23:0] cur_addr;
    int          cur_len, cur_half, last_half;
    int          rdy_mode = 0;
    logic [7:0]  lf = 8'hA5;
    int          hold_cnt = 0;

    int          idx, lo_cnt, hi_cnt, gap_cnt;
    logic [31:0] hdr;
    logic [23:0] dev_addr;
    logic        prev_sck = 0, prev_cs = 1, prev_ov = 0, prev_rdy = 1;
    logic [7:0]  prev_data = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            chk(0, "watchdog", cyc, 150000);
            finish_up();
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: begin
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    out_ready = lf[0] | lf[3];
                end
                default: begin
                    hold_cnt++;
                    out_ready = (hold_cnt % 50) > 38;
                end
            endcase

            if (prev_ov && !prev_rdy)
                chk(out_valid && (out_data == prev_data), "R8 held byte", out_data, prev_data);

            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(0, "R7 extra byte", out_data, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R5 data byte", out_data, e);
                end
            end

            if (prev_cs && !fl_cs_n) begin
                chk(gap_cnt >= last_half + 1, "R10 deselect time", gap_cnt, last_half + 1);
                idx = 0; hdr = '0; lo_cnt = 0;
            end

            if (prev_sck && !fl_sck) begin
                chk(hi_cnt == cur_half + 1, "R6 high phase", hi_cnt, cur_half + 1);
                lo_cnt = 0;
                if (!fl_cs_n) begin
                    if (idx >= 40) begin
                        int b, p;
                        logic [7:0] v;
                        b = (idx - 40) / 4;
                        p = (idx - 40) % 4;
                        v = mem_byte(dev_addr + 24'(b));
                        fl_rx_odd  = v[7 - 2*p];
                        fl_rx_even = v[6 - 2*p];
                    end else begin
                        fl_rx_odd  = 1'b1;
                        fl_rx_even = 1'b1;
                    end
                end
            end

            if (!prev_cs && fl_cs_n) begin
                chk(done == 1'b1, "R7 done with deselect", done, 1);
                chk(idx == 40 + 4*cur_len, "R7 clock count", idx, 40 + 4*cur_len);
                gap_cnt = 0;
                last_half = cur_half;
            end

            if (fl_cs_n) begin
                chk(fl_sck == 1'b0, "R6 clock parked", fl_sck, 0);
                gap_cnt++;
            end

            if (!prev_sck && fl_sck && !fl_cs_n) begin
                if (idx < 40 || ((idx - 40) % 4) != 0)
                    chk(lo_cnt == cur_half + 1, "R6 low phase", lo_cnt, cur_half + 1);
                else begin
                    chk(lo_cnt >= cur_half + 1, "R6 low phase min", lo_cnt, cur_half + 1);
                    chk(!prev_ov, "R8 no byte start while full", prev_ov, 0);
                end
                if (idx < 32) hdr = {hdr[30:0], fl_mosi};
                if (idx == 31) begin
                    chk(hdr[31:24] == CMD, "R2 command byte", hdr[31:24], CMD);
                    chk(hdr[23:0] == cur_addr, "R3 address", hdr[23:0], cur_addr);
                    dev_addr = hdr[23:0];
                end
                if (idx >= 32 && idx < 40)
                    chk(fl_mosi == 1'b0, "R4 dummy line low", fl_mosi, 0);
                idx++;
                hi_cnt = 0;
            end

            if (!fl_cs_n && !fl_sck) lo_cnt++;
            if (fl_sck) hi_cnt++;

            prev_sck  = fl_sck;
            prev_cs   = fl_cs_n;
            prev_ov   = out_valid;
            prev_rdy  = out_ready;
            prev_data = out_data;
        end
    end

    task automatic do_req(input logic [23:0] a, input int len, input int half, input int mode);
        int t;
        t = 0;
        @(negedge clk);
        while (!req_ready && t < 20000) begin @(negedge clk); t++; end
        cur_addr = a; cur_len = len; cur_half = half; rdy_mode = mode;
        for (int i = 0; i < len; i++) exp_q.push_back(mem_byte(a + 24'(i)));
        req_valid = 1'b1; req_addr = a; req_len = 16'(len); cfg_half = 8'(half);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_half = 8'(half + 3);
        if (len == 0) begin
            chk(done == 1'b1, "R9 empty done", done, 1);
            chk(fl_cs_n == 1'b1, "R9 bus untouched", fl_cs_n, 1);
            return;
        end
        req_valid = 1'b1; req_addr = 24'h00AAAA; req_len = 16'd7;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R11 busy not ready", req_ready, 0);
        end
        req_valid = 1'b0;
        t = 0;
        while (!done && t < 40000) begin @(negedge clk); t++; end
        chk(done == 1'b1, "R7 transfer finished", done, 1);
        t = 0;
        while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
        chk(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
    endtask

    initial begin
        gap_cnt = 1000; last_half = 0; cur_half = 0; cur_len = 0;
        idx = 0; lo_cnt = 0; hi_cnt = 0; hdr = '0; dev_addr = '0; cur_addr = '0;
        repeat (4) @(negedge clk);
        chk(fl_cs_n == 1'b1, "R1 reset cs", fl_cs_n, 1);
        chk(fl_sck == 1'b0, "R1 reset sck", fl_sck, 0);
        chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1;

        do_req(24'h000100, 3, 0, 0);
        do_req(24'h123456, 5, 2, 1);
        do_req(24'hC0FFFE, 4, 1, 2);
        do_req(24'h000040, 0, 1, 0);
        do_req(24'h7FFFFF, 6, 0, 2);
        do_req(24'h3A5C01, 1, 3, 1);
        do_req(24'h3A5C02, 2, 0, 0);
        repeat (10) @(negedge clk);
        finish_up();
    end
endmodule